// File: doc/BRIEF.md
# Tiered Memory Lookup Sequencer

This block is the load/store front end that turns one CPU-side request into traffic on three independent Wishbone master ports, wired to a first-level store, a second-level store and main memory. A read is tried on one level at a time, in that order. The block returns the first level that acknowledges. If every level answers with an error, it reports an address fault instead of data.

A write follows the write-through policy. It opens cycles on all three ports in the same clock. Each port stays active until its own slave terminates it, and the request completes only when the last port has finished.

The request port also supports reservations. A reservation op latches an address as held without moving any data. It can later be dropped, or consumed by a write to that address. Only one request is outstanding at any time.

Top module: `tier_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1, every `wb_cyc_o`/`wb_stb_o` bit is 0, `rsp_valid_o` is 0 and `rsv_valid_o` is 0.
- R2: A read (op 2'b00) is issued first to level 0. A level that is not needed is never touched: when level 0 acknowledges, levels 1 and 2 see no cycle. The response then carries that level's data and `rsp_level_o` = 0.
- R3: When level n (n < 2) ends a read with ERR, the cycle on level n+1 begins in the clock immediately after the ERR. The response names the serving level (1 or 2) and carries its data.
- R4: When all three levels return ERR on a read, the response has `rsp_err_o` = 1, `rsp_level_o` = 3 and `rsp_rdata_o` = 0.
- R5: A write (op 2'b01) raises CYC on all three ports in the same clock. Each port carries the same address, write data and byte selects, with WE = 1.
- R6: During a write, each port holds CYC and STB until its own ACK or ERR arrives. The response appears only after the slowest port has terminated.
- R7: A write responds with `rsp_err_o` = 1 if any port returned ERR, and with 0 otherwise.
- R8: `req_ready_o` is 0 from the clock after a bus request is accepted until the clock in which `rsp_valid_o` is 1. `rsp_valid_o` is a single-clock pulse per request.
- R9: A read reaches its serving level with the request's byte selects unchanged and WE = 0.
- R10: Reserve (op 2'b10) sets `rsv_valid_o`, loads `rsv_addr_o` with the request address and responds without error, all with no bus cycle on any port. Drop (op 2'b11) clears `rsv_valid_o`, again with no bus cycle. A write to the reserved address clears the reservation. A read leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_op_i | input | 2 | 00 read, 01 write, 10 reserve, 11 drop |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| req_sel_i | input | DW/8 | Byte selects |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Address error / write error |
| rsp_level_o | output | 2 | Serving level, 3 for none |
| rsp_rdata_o | output | DW | Read data |
| rsv_valid_o | output | 1 | Reservation held |
| rsv_addr_o | output | AW | Reserved address |
| wb_cyc_o | output | 3 | Per-level CYC |
| wb_stb_o | output | 3 | Per-level STB |
| wb_we_o | output | 3 | Per-level WE |
| wb_adr_o | output | 3*AW | Per-level address |
| wb_dat_o | output | 3*DW | Per-level write data |
| wb_sel_o | output | 3*DW/8 | Per-level byte selects |
| wb_dat_i | input | 3*DW | Per-level read data |
| wb_ack_i | input | 3 | Per-level ACK |
| wb_err_i | input | 3 | Per-level ERR |

## Verification
Several properties are checked in every clock:
- During a read, at most one port is active.
- A later level's cycle begins only directly after an ERR from the level before it.
- A write raises all three CYC lines together.
- A port never drops CYC before its own termination.
- Ready stays low while any port is busy.

Other behaviour needs the directed scenarios:
- Whether each response carries the correct data, level and error flag.
- Whether untouched levels really stay idle.
- That a write completes only after the slowest of three staggered slaves.
- How the reservation register behaves across reserve, drop, read and write.

// File: rtl/tier_pkg.sv
package tier_pkg;
  localparam int NLVL = 3;
  localparam int LW   = 2;
  localparam logic [LW-1:0] LVL_NONE = 2'd3;

  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WR   = 2'b01,
    OP_RSV  = 2'b10,
    OP_DROP = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } st_e;
endpackage

// File: rtl/tier_port.sv
module tier_port #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  input  logic [SW-1:0] sel_i,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  output logic [SW-1:0] wb_sel_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i,
  input  logic          wb_err_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          busy_q <= 1'b0;
    else if (start_i)                     busy_q <= 1'b1;
    else if (busy_q && (wb_ack_i || wb_err_i)) busy_q <= 1'b0;
  end

  assign wb_cyc_o = busy_q;
  assign wb_stb_o = busy_q;
  assign wb_we_o  = busy_q & we_i;
  assign wb_adr_o = busy_q ? adr_i : '0;
  assign wb_dat_o = busy_q ? dat_i : '0;
  assign wb_sel_o = busy_q ? sel_i : '0;
  assign busy_o   = busy_q;
  assign done_o   = busy_q & (wb_ack_i | wb_err_i);
  assign err_o    = busy_q & wb_err_i;
  assign rdata_o  = wb_dat_i;

  AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i && !wb_err_i) |=> (wb_cyc_o && wb_stb_o)); // R6
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !wb_cyc_o); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_QUIET: assert (!wb_cyc_o && !wb_stb_o); // R1
  end
endmodule

// File: rtl/tier_rsv.sv
module tier_rsv #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          drop_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          wr_done_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr_i;
    end else if (drop_i) begin
      valid_q <= 1'b0;
    end else if (wr_done_i && valid_q && (wr_addr_i == addr_q)) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  AST_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !valid_o); // R10
endmodule

// File: rtl/tier_fsm.sv
module tier_fsm
  import tier_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [1:0]               req_op_i,
  input  logic [AW-1:0]            req_addr_i,
  input  logic [DW-1:0]            req_wdata_i,
  input  logic [SW-1:0]            req_sel_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_err_o,
  output logic [LW-1:0]            rsp_level_o,
  output logic [DW-1:0]            rsp_rdata_o,
  output logic [NLVL-1:0]          start_o,
  output logic                     lat_we_o,
  output logic [AW-1:0]            lat_adr_o,
  output logic [DW-1:0]            lat_dat_o,
  output logic [SW-1:0]            lat_sel_o,
  input  logic [NLVL-1:0]          port_busy_i,
  input  logic [NLVL-1:0]          port_done_i,
  input  logic [NLVL-1:0]          port_err_i,
  input  logic [NLVL-1:0][DW-1:0]  port_rdata_i,
  output logic                     rsv_set_o,
  output logic                     rsv_drop_o,
  output logic                     wr_done_o
);
  st_e           st_q;
  logic [LW-1:0] lvl_q;
  logic          werr_q;
  logic          accept;
  logic          all_fin;
  op_e           op;

  assign op          = op_e'(req_op_i);
  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign all_fin     = ((port_busy_i & ~port_done_i) == '0);
  assign wr_done_o   = (st_q == S_WR) && all_fin;
  assign rsv_set_o   = accept && (op == OP_RSV);
  assign rsv_drop_o  = accept && (op == OP_DROP);

  always_comb begin
    start_o = '0;
    if (accept && op == OP_RD) start_o = NLVL'(1);
    if (accept && op == OP_WR) start_o = '1;
    if (st_q == S_RD && port_done_i[lvl_q] && port_err_i[lvl_q] && lvl_q != LW'(NLVL-1))
      start_o = NLVL'(1) << (lvl_q + LW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      lvl_q       <= '0;
      werr_q      <= 1'b0;
      lat_we_o    <= 1'b0;
      lat_adr_o   <= '0;
      lat_dat_o   <= '0;
      lat_sel_o   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_level_o <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          lat_adr_o <= req_addr_i;
          lat_dat_o <= req_wdata_i;
          lat_sel_o <= req_sel_i;
          lat_we_o  <= (op == OP_WR);
          lvl_q     <= '0;
          werr_q    <= 1'b0;
          if (op == OP_RD)      st_q <= S_RD;
          else if (op == OP_WR) st_q <= S_WR;
          else begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b0;
            rsp_level_o <= LVL_NONE;
            rsp_rdata_o <= '0;
          end
        end
        S_RD: if (port_done_i[lvl_q]) begin
          if (!port_err_i[lvl_q]) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b0;
            rsp_level_o <= lvl_q;
            rsp_rdata_o <= port_rdata_i[lvl_q];
            st_q        <= S_IDLE;
          end else if (lvl_q == LW'(NLVL-1)) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b1;
            rsp_level_o <= LVL_NONE;
            rsp_rdata_o <= '0;
            st_q        <= S_IDLE;
          end else begin
            lvl_q <= lvl_q + LW'(1);
          end
        end
        S_WR: begin
          werr_q <= werr_q | (|port_err_i);
          if (all_fin) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= werr_q | (|port_err_i);
            rsp_level_o <= '0;
            rsp_rdata_o <= '0;
            st_q        <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RD) |-> ($countones(port_busy_i) <= 1)); // R2
  AST_FALLBACK_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(port_busy_i[1]) && !lat_we_o) |-> $past(port_err_i[0])); // R3
  AST_FALLBACK_L2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(port_busy_i[2]) && !lat_we_o) |-> $past(port_err_i[1])); // R3
  AST_WR_FANOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(port_busy_i[0]) && lat_we_o) |-> (&port_busy_i)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_busy_i) |-> !req_ready_o); // R8
endmodule

// File: rtl/tier_seq.sv
module tier_seq
  import tier_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [1:0]              req_op_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [DW-1:0]           req_wdata_i,
  input  logic [SW-1:0]           req_sel_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_err_o,
  output logic [1:0]              rsp_level_o,
  output logic [DW-1:0]           rsp_rdata_o,
  output logic                    rsv_valid_o,
  output logic [AW-1:0]           rsv_addr_o,
  output logic [2:0]              wb_cyc_o,
  output logic [2:0]              wb_stb_o,
  output logic [2:0]              wb_we_o,
  output logic [2:0][AW-1:0]      wb_adr_o,
  output logic [2:0][DW-1:0]      wb_dat_o,
  output logic [2:0][SW-1:0]      wb_sel_o,
  input  logic [2:0][DW-1:0]      wb_dat_i,
  input  logic [2:0]              wb_ack_i,
  input  logic [2:0]              wb_err_i
);
  logic [NLVL-1:0]         start;
  logic [NLVL-1:0]         p_busy, p_done, p_err;
  logic [NLVL-1:0][DW-1:0] p_rdata;
  logic                    lat_we;
  logic [AW-1:0]           lat_adr;
  logic [DW-1:0]           lat_dat;
  logic [SW-1:0]           lat_sel;
  logic                    rsv_set, rsv_drop, wr_done;

  tier_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i, .req_wdata_i, .req_sel_i,
    .rsp_valid_o, .rsp_err_o, .rsp_level_o, .rsp_rdata_o,
    .start_o(start), .lat_we_o(lat_we), .lat_adr_o(lat_adr),
    .lat_dat_o(lat_dat), .lat_sel_o(lat_sel),
    .port_busy_i(p_busy), .port_done_i(p_done), .port_err_i(p_err),
    .port_rdata_i(p_rdata),
    .rsv_set_o(rsv_set), .rsv_drop_o(rsv_drop), .wr_done_o(wr_done)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    tier_port #(.AW(AW), .DW(DW)) u_port (
      .clk_i, .rst_ni,
      .start_i(start[g]), .we_i(lat_we), .adr_i(lat_adr), .dat_i(lat_dat), .sel_i(lat_sel),
      .wb_cyc_o(wb_cyc_o[g]), .wb_stb_o(wb_stb_o[g]), .wb_we_o(wb_we_o[g]),
      .wb_adr_o(wb_adr_o[g]), .wb_dat_o(wb_dat_o[g]), .wb_sel_o(wb_sel_o[g]),
      .wb_dat_i(wb_dat_i[g]), .wb_ack_i(wb_ack_i[g]), .wb_err_i(wb_err_i[g]),
      .busy_o(p_busy[g]), .done_o(p_done[g]), .err_o(p_err[g]), .rdata_o(p_rdata[g])
    );
  end

  tier_rsv #(.AW(AW)) u_rsv (
    .clk_i, .rst_ni,
    .set_i(rsv_set), .drop_i(rsv_drop), .set_addr_i(req_addr_i),
    .wr_done_i(wr_done), .wr_addr_i(lat_adr),
    .valid_o(rsv_valid_o), .addr_o(rsv_addr_o)
  );
endmodule

// File: tb/tb_tier_seq.sv
module tb_tier_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [SW-1:0] req_sel = '0;
  logic rsp_valid, rsp_err;
  logic [1:0] rsp_level;
  logic [DW-1:0] rsp_rdata;
  logic rsv_valid;
  logic [AW-1:0] rsv_addr;
  logic [2:0] wb_cyc, wb_stb, wb_we;
  logic [2:0][AW-1:0] wb_adr;
  logic [2:0][DW-1:0] wb_dat_o, wb_dat_i;
  logic [2:0][SW-1:0] wb_sel;
  logic [2:0] wb_ack, wb_err;

  tier_seq #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_sel_i(req_sel),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_level_o(rsp_level),
    .rsp_rdata_o(rsp_rdata), .rsv_valid_o(rsv_valid), .rsv_addr_o(rsv_addr),
    .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_we_o(wb_we), .wb_adr_o(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel), .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack), .wb_err_i(wb_err)
  );

  // slave models
  int lat [3];
  bit fail [3];
  int cnt [3];

  function automatic logic [DW-1:0] lvl_data(int l, logic [AW-1:0] a);
    return a ^ (32'h1111_1111 * (l + 1));
  endfunction

  always_comb begin
    for (int i = 0; i < 3; i++) wb_dat_i[i] = lvl_data(i, wb_adr[i]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack <= '0;
      wb_err <= '0;
      for (int i = 0; i < 3; i++) cnt[i] <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        wb_ack[i] <= 1'b0;
        wb_err[i] <= 1'b0;
        if (wb_cyc[i] && wb_stb[i] && !wb_ack[i] && !wb_err[i]) begin
          if (cnt[i] == lat[i]) begin
            if (fail[i]) wb_err[i] <= 1'b1;
            else         wb_ack[i] <= 1'b1;
            cnt[i] <= 0;
          end else cnt[i] <= cnt[i] + 1;
        end
      end
    end
  end

  // bus monitor
  int cyc_n = 0;
  int hits [3];
  int rise_c [3];
  int resp_c [3];
  logic [AW-1:0] cap_adr [3];
  logic [DW-1:0] cap_dat [3];
  logic [SW-1:0] cap_sel [3];
  logic cap_we [3];
  logic prev_cyc [3];

  initial begin
    for (int i = 0; i < 3; i++) begin
      hits[i] = 0; rise_c[i] = 0; resp_c[i] = 0; prev_cyc[i] = 1'b0;
      cap_adr[i] = '0; cap_dat[i] = '0; cap_sel[i] = '0; cap_we[i] = 1'b0;
      lat[i] = 0; fail[i] = 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc_n++;
    for (int i = 0; i < 3; i++) begin
      if (wb_cyc[i] && !prev_cyc[i]) rise_c[i] = cyc_n;
      if (wb_cyc[i] && (wb_ack[i] || wb_err[i])) begin
        hits[i]++;
        resp_c[i]  = cyc_n;
        cap_adr[i] = wb_adr[i];
        cap_dat[i] = wb_dat_o[i];
        cap_sel[i] = wb_sel[i];
        cap_we[i]  = wb_we[i];
      end
      prev_cyc[i] = wb_cyc[i];
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  logic r_err;
  logic [1:0] r_lvl;
  logic [DW-1:0] r_data;
  int r_cyc;
  bit r_rdy_bad;
  bit r_timeout;

  task automatic do_req(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    tick();
    chk(req_ready == 1'b1, "R8", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_sel = s;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    r_rdy_bad = 1'b0;
    r_timeout = 1'b1;
    for (int n = 0; n < 200; n++) begin
      tick();
      if (rsp_valid) begin
        r_err = rsp_err; r_lvl = rsp_level; r_data = rsp_rdata; r_cyc = cyc_n;
        r_timeout = 1'b0;
        break;
      end
      if (req_ready) r_rdy_bad = 1'b1;
    end
    chk(!r_timeout, "R8", "response arrived", 64'(r_timeout), 64'd0);
    chk(!r_rdy_bad && req_ready, "R8", "ready low until response", 64'(r_rdy_bad), 64'd0);
    tick();
    chk(!rsp_valid || op[1], "R8", "response is one pulse", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    chk(wb_cyc == 3'b000 && wb_stb == 3'b000, "R1", "cyc/stb after reset",
        64'({wb_cyc, wb_stb}), 64'd0);
    chk(!rsp_valid && !rsv_valid, "R1", "rsp/rsv after reset",
        64'({rsp_valid, rsv_valid}), 64'd0);
  endtask

  task automatic t_read(string req, bit f0, bit f1, bit f2, int l0, int l1, int l2,
                        logic [AW-1:0] a, logic [SW-1:0] s);
    int base [3];
    int last;
    int served;
    fail[0] = f0; fail[1] = f1; fail[2] = f2;
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
    for (int i = 0; i < 3; i++) base[i] = hits[i];
    served = !f0 ? 0 : !f1 ? 1 : !f2 ? 2 : 3;
    last = (served == 3) ? 2 : served;
    do_req(2'b00, a, 32'hDEAD_BEEF, s);
    if (served == 3) begin
      chk(r_err == 1'b1, "R4", "all-fail error flag", 64'(r_err), 64'd1);
      chk(r_lvl == 2'd3, "R4", "all-fail level", 64'(r_lvl), 64'd3);
      chk(r_data == '0, "R4", "all-fail data", 64'(r_data), 64'd0);
    end else begin
      chk(r_err == 1'b0, req, "read error flag", 64'(r_err), 64'd0);
      chk(r_lvl == 2'(served), req, "serving level", 64'(r_lvl), 64'(served));
      chk(r_data == lvl_data(served, a), req, "read data", 64'(r_data), 64'(lvl_data(served, a)));
      chk(cap_sel[served] == s && cap_we[served] == 1'b0 && cap_adr[served] == a, "R9",
          "sel/we/adr at serving level", 64'({cap_we[served], cap_sel[served]}), 64'({1'b0, s}));
    end
    for (int k = 0; k < 3; k++) begin
      chk(hits[k] - base[k] == ((k <= last) ? 1 : 0), "R2", $sformatf("level %0d touched", k),
          64'(hits[k] - base[k]), 64'((k <= last) ? 1 : 0));
      if (k >= 1 && k <= last)
        chk(rise_c[k] == resp_c[k-1] + 1, "R3", $sformatf("fallback timing to level %0d", k),
            64'(rise_c[k]), 64'(resp_c[k-1] + 1));
    end
  endtask

  task automatic t_write(bit f0, bit f1, bit f2, int l0, int l1, int l2,
                         logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    int base [3];
    int mx;
    int st;
    fail[0] = f0; fail[1] = f1; fail[2] = f2;
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
    for (int i = 0; i < 3; i++) base[i] = hits[i];
    st = cyc_n;
    do_req(2'b01, a, d, s);
    chk(rise_c[0] > st && rise_c[0] == rise_c[1] && rise_c[1] == rise_c[2], "R5",
        "write cyc rises together", 64'({rise_c[0][15:0], rise_c[1][15:0], rise_c[2][15:0]}),
        64'({rise_c[0][15:0], rise_c[0][15:0], rise_c[0][15:0]}));
    mx = 0;
    for (int k = 0; k < 3; k++) begin
      chk(cap_adr[k] == a && cap_dat[k] == d && cap_sel[k] == s && cap_we[k], "R5",
          $sformatf("write fields on level %0d", k), 64'({cap_we[k], cap_sel[k], cap_dat[k]}),
          64'({1'b1, s, d}));
      chk(hits[k] - base[k] == 1, "R6", $sformatf("level %0d terminated once", k),
          64'(hits[k] - base[k]), 64'd1);
      if (resp_c[k] > mx) mx = resp_c[k];
    end
    chk(r_cyc > mx, "R6", "response after slowest port", 64'(r_cyc), 64'(mx + 1));
    chk(r_err == (f0 | f1 | f2), "R7", "write error flag", 64'(r_err), 64'(f0 | f1 | f2));
  endtask

  task automatic t_rsv();
    int base;
    for (int i = 0; i < 3; i++) begin fail[i] = 1'b0; lat[i] = 0; end
    base = hits[0] + hits[1] + hits[2];
    do_req(2'b10, 32'h0000_4000, '0, '0);
    chk(r_err == 1'b0, "R10", "reserve no error", 64'(r_err), 64'd0);
    chk(rsv_valid && rsv_addr == 32'h0000_4000, "R10", "reserve latched",
        64'({rsv_valid, rsv_addr}), 64'({1'b1, 32'h0000_4000}));
    chk(hits[0] + hits[1] + hits[2] == base, "R10", "reserve no bus cycle",
        64'(hits[0] + hits[1] + hits[2] - base), 64'd0);
    do_req(2'b00, 32'h0000_4000, '0, 4'hF);
    chk(rsv_valid == 1'b1, "R10", "read keeps reservation", 64'(rsv_valid), 64'd1);
    base = hits[0] + hits[1] + hits[2];
    do_req(2'b11, 32'h0, '0, '0);
    chk(rsv_valid == 1'b0, "R10", "drop clears", 64'(rsv_valid), 64'd0);
    chk(hits[0] + hits[1] + hits[2] == base, "R10", "drop no bus cycle",
        64'(hits[0] + hits[1] + hits[2] - base), 64'd0);
    do_req(2'b10, 32'h0000_5000, '0, '0);
    do_req(2'b01, 32'h0000_5004, 32'h1234_5678, 4'hF);
    chk(rsv_valid == 1'b1, "R10", "other write keeps", 64'(rsv_valid), 64'd1);
    do_req(2'b01, 32'h0000_5000, 32'h8765_4321, 4'h3);
    chk(rsv_valid == 1'b0, "R10", "matching write clears", 64'(rsv_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read("R2", 1'b0, 1'b0, 1'b0, 0, 0, 0, 32'h0000_0100, 4'hF);
    t_read("R2", 1'b0, 1'b1, 1'b1, 3, 0, 0, 32'h0000_0204, 4'h3);
    t_read("R3", 1'b1, 1'b0, 1'b0, 0, 2, 0, 32'h0000_0308, 4'hC);
    t_read("R3", 1'b1, 1'b1, 1'b0, 1, 0, 3, 32'h0000_040C, 4'h1);
    t_read("R4", 1'b1, 1'b1, 1'b1, 0, 1, 2, 32'h0000_0510, 4'h8);
    t_write(1'b0, 1'b0, 1'b0, 0, 2, 4, 32'h0000_0600, 32'hA5A5_0001, 4'hF);
    t_write(1'b0, 1'b1, 1'b0, 3, 0, 1, 32'h0000_0704, 32'h5A5A_0002, 4'h6);
    t_write(1'b1, 1'b1, 1'b1, 5, 0, 0, 32'h0000_0808, 32'h0F0F_0003, 4'h9);
    t_rsv();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule